// File: doc/BRIEF.md
# Limb-wise Signed/Unsigned Less-Than Comparator

This block compares two 32-bit integers for an integer execution unit. Each operand arrives as four 8-bit limbs, with limb 0 the least significant and limb 3 the most significant. An absolute opcode selects a signed or an unsigned comparison. The block subtracts a fixed base from that opcode to decode it.

The decision scans the limbs from the top down. It stops at the first limb where the operands differ. It compares that limb pair as unsigned bytes and XORs the outcome with the two operand sign flags. The one-bit answer is written into limb 0 of a 4-limb result word.

Alongside the answer, the block reports several side outputs: a one-hot marker of the deciding limb, the index of that limb, the byte difference (y minus x) at that limb, the sign flags it applied, and an illegal-opcode flag. All outputs are registered. A result appears one cycle after a valid input and stays stable until the next valid input.

Top module: `ltc_cmp`

## Requirements
- R1: Opcode 0x310 selects a signed comparison and 0x311 selects an unsigned comparison; the mode comes from the opcode minus the 0x310 base.
- R2: In signed mode, each sign flag equals bit 31 of its operand (the top bit of limb 3, limbs packed with limb 0 in bits 7:0). In unsigned mode, and for an illegal opcode, both flags are 0.
- R3: Let i be the highest limb index where x and y differ. The result is (x limb i < y limb i, compared unsigned) XOR x sign XOR y sign. This equals x < y as two's-complement values in signed mode and as unsigned values in unsigned mode.
- R4: When the operands are equal, the result is 0, the index is 0, the marker is all zero and the difference is 0.
- R5: The 4-bit marker has exactly bit i set, and the 2-bit index output equals i, whenever the operands differ.
- R6: The difference output equals (y limb i − x limb i) mod 256.
- R7: Bit 0 of the 32-bit result word carries the result, and bits 31:1 are zero.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. While in_valid is low, every data output holds its value.
- R9: Any other opcode gives a result of 0 with the illegal flag set. Both legal opcodes give an illegal flag of 0.
- R10: After synchronous reset, out_valid and every data output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| in_opcode | input | 12 | Absolute opcode (0x310 signed, 0x311 unsigned) |
| in_x | input | 32 | First operand, limb 0 in bits 7:0 |
| in_y | input | 32 | Second operand, limb 0 in bits 7:0 |
| out_valid | output | 1 | Registered result is new this cycle |
| out_word | output | 32 | Result word, comparison bit in bit 0 |
| out_lt | output | 1 | Comparison bit |
| out_marker | output | 4 | One-hot deciding-limb marker |
| out_index | output | 2 | Deciding-limb index |
| out_diff | output | 8 | y minus x at the deciding limb |
| out_x_sign | output | 1 | Sign flag applied for x |
| out_y_sign | output | 1 | Sign flag applied for y |
| out_illegal | output | 1 | Opcode was neither legal value |

## Verification
The assertions check structural properties on every cycle. They confirm that the marker is at most one-hot, that the upper bits of the result word stay zero, and that the result bit matches bit 0 of the word. They also check that an all-zero marker comes with zero index and difference, that an illegal opcode forces the result and sign flags to zero, and that the valid timing and hold behaviour are correct.

Whether the comparison answer, the chosen limb and the difference are numerically right depends on the operand values. Only the bench scenarios can show this. Those scenarios are the two worked operand pairs, equal and nearly-equal operands, sign-boundary values, and random pairs that share a random number of upper limbs.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

    localparam int LIMBS   = 4;
    localparam int LIMB_W  = 8;
    localparam int WORD_W  = LIMBS * LIMB_W;
    localparam int OPC_W   = 12;
    localparam int IDX_W   = (LIMBS > 1) ? $clog2(LIMBS) : 1;

    localparam logic [OPC_W-1:0] OPC_BASE = 12'h310;

    typedef enum logic [1:0] {
        MODE_SIGNED   = 2'd0,
        MODE_UNSIGNED = 2'd1,
        MODE_ILLEGAL  = 2'd2
    } cmp_mode_e;

    function automatic cmp_mode_e decode_opcode(input logic [OPC_W-1:0] op);
        logic [OPC_W-1:0] rel;
        rel = op - OPC_BASE;
        case (rel)
            12'd0:   return MODE_SIGNED;
            12'd1:   return MODE_UNSIGNED;
            default: return MODE_ILLEGAL;
        endcase
    endfunction

    typedef struct packed {
        logic                lt;
        logic [LIMBS-1:0]    marker;
        logic [IDX_W-1:0]    index;
        logic [LIMB_W-1:0]   diff;
        logic                x_sign;
        logic                y_sign;
        logic                illegal;
    } cmp_result_t;

endpackage

// File: rtl/ltc_opdecode.sv
module ltc_opdecode
    import ltc_pkg::*;
#(
    parameter int OPCODE_W = OPC_W
) (
    input  logic [OPCODE_W-1:0] opcode,
    output cmp_mode_e           mode,
    output logic                signed_en,
    output logic                illegal
);
    always_comb begin
        mode      = decode_opcode(opcode);
        signed_en = (mode == MODE_SIGNED);
        illegal   = (mode == MODE_ILLEGAL);
    end
endmodule

// File: rtl/ltc_sign.sv
module ltc_sign #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              signed_en,
    output logic              x_sign,
    output logic              y_sign
);
    assign x_sign = signed_en & x[DATA_W-1];
    assign y_sign = signed_en & y[DATA_W-1];
endmodule

// File: rtl/ltc_limb_scan.sv
module ltc_limb_scan #(
    parameter int N_LIMBS = 4,
    parameter int L_W     = 8,
    localparam int D_W    = N_LIMBS * L_W,
    localparam int I_W    = (N_LIMBS > 1) ? $clog2(N_LIMBS) : 1
) (
    input  logic [D_W-1:0]     x,
    input  logic [D_W-1:0]     y,
    output logic               any_diff,
    output logic [N_LIMBS-1:0] marker,
    output logic [I_W-1:0]     index,
    output logic [L_W-1:0]     diff,
    output logic               raw_lt
);
    logic [L_W-1:0]     xl  [N_LIMBS];
    logic [L_W-1:0]     yl  [N_LIMBS];
    logic [N_LIMBS-1:0] neq;

    genvar g;
    generate
        for (g = 0; g < N_LIMBS; g++) begin : g_limb
            assign xl[g]  = x[g*L_W +: L_W];
            assign yl[g]  = y[g*L_W +: L_W];
            assign neq[g] = (xl[g] != yl[g]);
        end
    endgenerate

    always_comb begin
        any_diff = 1'b0;
        marker   = '0;
        index    = '0;
        diff     = '0;
        raw_lt   = 1'b0;
        for (int i = N_LIMBS - 1; i >= 0; i--) begin
            if (!any_diff && neq[i]) begin
                any_diff  = 1'b1;
                marker[i] = 1'b1;
                index     = I_W'(i);
                diff      = yl[i] - xl[i];
                raw_lt    = (xl[i] < yl[i]);
            end
        end
    end
endmodule

// File: rtl/ltc_cmp.sv
module ltc_cmp
    import ltc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [WORD_W-1:0] in_x,
    input  logic [WORD_W-1:0] in_y,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_lt,
    output logic [LIMBS-1:0]  out_marker,
    output logic [IDX_W-1:0]  out_index,
    output logic [LIMB_W-1:0] out_diff,
    output logic              out_x_sign,
    output logic              out_y_sign,
    output logic              out_illegal
);
    cmp_mode_e          mode;
    logic               signed_en;
    logic               illegal;
    logic               xs;
    logic               ys;
    logic               any_diff;
    logic [LIMBS-1:0]   marker;
    logic [IDX_W-1:0]   index;
    logic [LIMB_W-1:0]  diff;
    logic               raw_lt;
    cmp_result_t        nxt;
    cmp_result_t        cur;
    logic               valid_q;

    ltc_opdecode #(.OPCODE_W(OPC_W)) u_dec (
        .opcode    (in_opcode),
        .mode      (mode),
        .signed_en (signed_en),
        .illegal   (illegal)
    );

    ltc_sign #(.DATA_W(WORD_W)) u_sign (
        .x         (in_x),
        .y         (in_y),
        .signed_en (signed_en),
        .x_sign    (xs),
        .y_sign    (ys)
    );

    ltc_limb_scan #(.N_LIMBS(LIMBS), .L_W(LIMB_W)) u_scan (
        .x        (in_x),
        .y        (in_y),
        .any_diff (any_diff),
        .marker   (marker),
        .index    (index),
        .diff     (diff),
        .raw_lt   (raw_lt)
    );

    always_comb begin
        nxt.marker  = marker;
        nxt.index   = index;
        nxt.diff    = diff;
        nxt.x_sign  = xs;
        nxt.y_sign  = ys;
        nxt.illegal = illegal;
        nxt.lt      = any_diff && !illegal && (raw_lt ^ xs ^ ys);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cur     <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                cur <= nxt;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_lt      = cur.lt;
    assign out_word    = {{(WORD_W-1){1'b0}}, cur.lt};
    assign out_marker  = cur.marker;
    assign out_index   = cur.index;
    assign out_diff    = cur.diff;
    assign out_x_sign  = cur.x_sign;
    assign out_y_sign  = cur.y_sign;
    assign out_illegal = cur.illegal;

    logic unused_mode;
    assign unused_mode = ^mode;
endmodule

// File: rtl/ltc_cmp_chk.sv
module ltc_cmp_chk
    import ltc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPC_W-1:0]  in_opcode,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              out_lt,
    input logic [LIMBS-1:0]  out_marker,
    input logic [IDX_W-1:0]  out_index,
    input logic [LIMB_W-1:0] out_diff,
    input logic              out_x_sign,
    input logic              out_y_sign,
    input logic              out_illegal
);
    // R5
    marker_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_marker));

    // R7
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_word[WORD_W-1:1] == '0) && (out_word[0] == out_lt));

    // R4
    equal_case_chk: assert property (@(posedge clk) disable iff (rst)
        (out_marker == '0) |-> (!out_lt && out_index == '0 && out_diff == '0));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_lt && !out_x_sign && !out_y_sign));

    // R2
    unsigned_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_opcode != OPC_BASE) |=> (!out_x_sign && !out_y_sign));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_word) && $stable(out_marker) && $stable(out_diff)
                       && $stable(out_index) && $stable(out_illegal)));
endmodule

bind ltc_cmp ltc_cmp_chk u_chk (.*);

// File: tb/ltc_cmp_bench.sv
module ltc_cmp_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [11:0] in_opcode;
    logic [31:0] in_x;
    logic [31:0] in_y;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_lt;
    logic [3:0]  out_marker;
    logic [1:0]  out_index;
    logic [7:0]  out_diff;
    logic        out_x_sign;
    logic        out_y_sign;
    logic        out_illegal;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;

    localparam logic [11:0] OP_S = 12'h310;
    localparam logic [11:0] OP_U = 12'h311;

    always #10 clk = ~clk;

    ltc_cmp u_ltc_cmp (
        .clk, .rst, .in_valid, .in_opcode, .in_x, .in_y,
        .out_valid, .out_word, .out_lt, .out_marker, .out_index,
        .out_diff, .out_x_sign, .out_y_sign, .out_illegal
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int top_diff(input logic [31:0] x, input logic [31:0] y);
        int k = -1;
        for (int i = 0; i < 4; i++)
            if (x[i*8 +: 8] != y[i*8 +: 8]) k = i;
        return k;
    endfunction

    task automatic check_expected(input logic [11:0] op, input logic [31:0] x, input logic [31:0] y);
        bit sgn = (op == OP_S);
        bit bad = (op != OP_S) && (op != OP_U);
        bit elt;
        int k = top_diff(x, y);
        logic [3:0] emk = '0;
        logic [1:0] eidx = '0;
        logic [7:0] edf = '0;
        if (bad) elt = 0;
        else if (sgn) elt = ($signed(x) < $signed(y));
        else elt = (x < y);
        if (k >= 0) begin
            emk[k] = 1'b1;
            eidx = 2'(k);
            edf = y[k*8 +: 8] - x[k*8 +: 8];
        end
        chk("R8 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R3 out_lt", {31'd0, out_lt}, {31'd0, elt});
        chk("R7 out_word", out_word, {31'd0, elt});
        chk("R5 out_marker", {28'd0, out_marker}, {28'd0, emk});
        chk("R5 out_index", {30'd0, out_index}, {30'd0, eidx});
        chk("R6 out_diff", {24'd0, out_diff}, {24'd0, edf});
        chk("R2 out_x_sign", {31'd0, out_x_sign}, {31'd0, sgn & x[31]});
        chk("R2 out_y_sign", {31'd0, out_y_sign}, {31'd0, sgn & y[31]});
        chk("R9 out_illegal", {31'd0, out_illegal}, {31'd0, bad});
    endtask

    task automatic apply(input logic [11:0] op, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_x = x; in_y = y;
        @(negedge clk);
        in_valid = 1'b0;
        in_x = ~x; in_y = y ^ 32'h5a5a_5a5a; in_opcode = 12'h000;
        check_expected(op, x, y);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx, ry, ow;
        int keep;
        in_valid = 0; in_opcode = 0; in_x = 0; in_y = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R10
        chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10 out_word", out_word, 32'd0);
        chk("R10 out_marker", {28'd0, out_marker}, 32'd0);
        chk("R10 out_illegal", {31'd0, out_illegal}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 worked pairs (limb 0 in low byte)
        apply(OP_U, 32'hCD19_2291, 32'hCD19_2349);
        chk("R1 unsigned diff idx1 lt", {31'd0, out_lt}, 32'd1);
        apply(OP_S, 32'hCD19_2291, 32'hCD19_2349);
        chk("R2 both signs set", {30'd0, out_x_sign, out_y_sign}, 32'd3);
        apply(OP_S, 32'h3719_232D, 32'hCD19_22AD);
        chk("R3 sign mix result", {31'd0, out_lt}, 32'd0);
        chk("R6 diff 150", {24'd0, out_diff}, 32'd150);
        apply(OP_U, 32'h3719_232D, 32'hCD19_22AD);
        chk("R1 unsigned same pair", {31'd0, out_lt}, 32'd1);

        // R4 equal operands
        apply(OP_S, 32'h8000_0000, 32'h8000_0000);
        apply(OP_U, 32'h0, 32'h0);
        // boundary values
        apply(OP_S, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(OP_S, 32'hFFFF_FFFF, 32'h0000_0000);
        apply(OP_U, 32'hFFFF_FFFF, 32'h0000_0000);
        apply(OP_S, 32'h1234_5600, 32'h1234_56FF);

        // R9 illegal opcodes
        apply(12'h312, 32'h0000_0001, 32'h0000_0002);
        chk("R9 illegal lt zero", {31'd0, out_lt}, 32'd0);
        apply(12'h30F, 32'h8000_0001, 32'h0000_0002);
        apply(12'h000, 32'h1, 32'h1);

        // R8 hold with idle cycles and changing inputs
        apply(OP_S, 32'h0000_0010, 32'h0000_2000);
        ow = out_word;
        repeat (4) @(negedge clk);
        chk("R8 idle out_valid low", {31'd0, out_valid}, 32'd0);
        chk("R8 hold word", out_word, ow);
        chk("R8 hold diff", {24'd0, out_diff}, 32'h20);

        // random with shared upper limbs
        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            rx = $urandom;
            ry = $urandom;
            keep = $urandom_range(0, 4);
            for (int b = 3; b >= 0; b--)
                if (3 - b < keep) ry[b*8 +: 8] = rx[b*8 +: 8];
            case ($urandom_range(0, 9))
                0:       apply(12'h300 + 12'($urandom_range(0, 63)), rx, ry);
                1, 2, 3, 4: apply(OP_S, rx, ry);
                default: apply(OP_U, rx, ry);
            endcase
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule